// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block works out the bit period of an incoming serial stream while a synchronization character arrives, and it stores the result as the baud divisor. Software arms it with an enable write. The receive line passes through a synchronizer. The first low-to-high transition of the line after arming clears a 16-bit measurement counter. From then on the counter advances once for every baud tick, until the fifth such transition. The synchronization character alternates its bits, so the span from the first to the fifth rising edge covers eight bit times.

On the fifth rising edge the counter value moves into the divisor register. The receive-interrupt flag is set and the enable status drops back to zero. A read strobe on the receive data register clears the interrupt flag. If the count goes past its 16-bit maximum before the fifth edge, a sticky overflow flag is raised. The counter wraps to zero and keeps counting until the fifth edge arrives.

Software clears the overflow flag with a clear strobe, but only once the enable is low. To abort a measurement, software first writes the enable to zero and then pulses the overflow clear.

Top module: `abd_top`

## Requirements
- R1: After reset, divisor is 0, and ovf_flag, rx_irq and en_status are all 0.
- R2: A cycle with en_wr high sets en_status to en_wdata from the next cycle on. Writing 1 arms a fresh measurement, and writing 0 abandons any measurement in progress.
- R3: While armed, a rising edge of rx_pin is a low sample followed by a high sample after a two-flop synchronizer, and it takes effect two clock edges after the first high sample. The first such edge sets the count to 0. Every cycle with baud_tick high that lies strictly between the first and the fifth rising edge adds one to the count.
- R4: On the fifth rising edge, divisor takes the count, rx_irq goes to 1 and en_status goes to 0, all on the same clock edge.
- R5: A cycle with data_rd high clears rx_irq on the next edge, unless a fifth rising edge sets it in that same cycle.
- R6: Rising edges of rx_pin while en_status is 0 have no effect: divisor, rx_irq and ovf_flag keep their values.
- R7: If the count passes 65535 before the fifth rising edge, ovf_flag is set and the counter wraps to 0 and keeps counting. At the fifth edge, divisor holds the total tick count modulo 65536.
- R8: Once set, ovf_flag stays 1 until a clear is accepted. The fifth rising edge does not clear it.
- R9: A cycle with ovf_clr high while en_status is 0 clears ovf_flag on the next edge.
- R10: A cycle with ovf_clr high while en_status is 1 has no effect on ovf_flag.
- R11: If en_status is written to 0 before the fifth rising edge, rx_irq is not set and divisor keeps its previous value, even when further rising edges arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Serial receive line, asynchronous, idles high |
| baud_tick | input | 1 | Counting tick, one cycle wide |
| en_wr | input | 1 | Write strobe for the auto-baud enable |
| en_wdata | input | 1 | Value written to the enable |
| ovf_clr | input | 1 | Software clear strobe for the overflow flag |
| data_rd | input | 1 | Read strobe of the receive data register |
| divisor | output | 16 | Measured baud divisor |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| rx_irq | output | 1 | Receive-interrupt flag |
| en_status | output | 1 | Enable status; 1 while armed or measuring |

## Verification
A pin level that is first sampled at clock edge c produces a rising edge that acts at edge c+2. The divisor, the interrupt and the enable drop from the fifth rising edge all appear together after that edge. The strobes en_wr, data_rd and ovf_clr show their effect after the one edge that samples them. The driver numbers each sampling edge and drives inputs on falling edges. From those numbers it computes the ticks that fall strictly between edge c1+2 and edge c5+2, and it queues that expected divisor and overflow value. The monitor compares at the falling edge that follows the rise of rx_irq, and the direct checks on strobes sample one falling edge after the strobe was sampled.

// File: rtl/abd_pkg.sv
package abd_pkg;

    localparam int unsigned ABD_CNT_W_DEF   = 16;
    localparam int unsigned ABD_EDGES_DEF   = 5;
    localparam int unsigned ABD_STAGES_DEF  = 2;

    typedef enum logic [1:0] {
        ABD_IDLE    = 2'd0,
        ABD_ARMED   = 2'd1,
        ABD_MEASURE = 2'd2
    } abd_phase_e;

endpackage

// File: rtl/abd_edge_sync.sv
module abd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], pin_i};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.sh[STAGES-1] & ~s_q.prev;

endmodule

// File: rtl/abd_counter.sv
module abd_counter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             at_max_o
);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + WIDTH'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o    = cnt_q;
    assign at_max_o = (cnt_q == {WIDTH{1'b1}});

endmodule

// File: rtl/abd_ctrl.sv
module abd_ctrl
    import abd_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned EDGES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             tick_i,
    input  logic             en_wr_i,
    input  logic             en_wdata_i,
    input  logic             ovf_clr_i,
    input  logic             data_rd_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_max_i,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output logic [CNT_W-1:0] div_o,
    output logic             ovf_o,
    output logic             irq_o,
    output logic             en_o
);

    localparam int unsigned EW = $clog2(EDGES);

    typedef struct packed {
        abd_phase_e       phase;
        logic [EW-1:0]    edges;
        logic             ovf;
        logic             irq;
        logic [CNT_W-1:0] div;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  clr_d, inc_d;

    always_comb begin
        c_d   = c_q;
        clr_d = 1'b0;
        inc_d = 1'b0;

        if (data_rd_i) begin
            c_d.irq = 1'b0;
        end
        if (ovf_clr_i && (c_q.phase == ABD_IDLE)) begin
            c_d.ovf = 1'b0;
        end

        case (c_q.phase)
            ABD_ARMED: begin
                if (rise_i) begin
                    c_d.phase = ABD_MEASURE;
                    c_d.edges = EW'(1);
                    clr_d     = 1'b1;
                end
            end
            ABD_MEASURE: begin
                if (rise_i && (c_q.edges == EW'(EDGES - 1))) begin
                    c_d.div   = cnt_i;
                    c_d.irq   = 1'b1;
                    c_d.phase = ABD_IDLE;
                    c_d.edges = '0;
                end else begin
                    if (rise_i) begin
                        c_d.edges = c_q.edges + EW'(1);
                    end
                    if (tick_i) begin
                        inc_d = 1'b1;
                        if (cnt_max_i) begin
                            c_d.ovf = 1'b1;
                        end
                    end
                end
            end
            default: ;
        endcase

        if (en_wr_i) begin
            c_d.phase = en_wdata_i ? ABD_ARMED : ABD_IDLE;
            c_d.edges = '0;
            inc_d     = 1'b0;
            clr_d     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{phase: ABD_IDLE, edges: '0, ovf: 1'b0, irq: 1'b0, div: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_clr_o = clr_d;
    assign cnt_inc_o = inc_d;
    assign div_o     = c_q.div;
    assign ovf_o     = c_q.ovf;
    assign irq_o     = c_q.irq;
    assign en_o      = (c_q.phase != ABD_IDLE);

endmodule

// File: rtl/abd_top.sv
module abd_top
    import abd_pkg::*;
#(
    parameter int unsigned CNT_W  = ABD_CNT_W_DEF,
    parameter int unsigned EDGES  = ABD_EDGES_DEF,
    parameter int unsigned STAGES = ABD_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_pin,
    input  logic             baud_tick,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             ovf_clr,
    input  logic             data_rd,
    output logic [CNT_W-1:0] divisor,
    output logic             ovf_flag,
    output logic             rx_irq,
    output logic             en_status
);

    logic             rx_rise;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             cnt_max;
    logic [CNT_W-1:0] cnt_val;

    abd_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (rx_pin),
        .rise_o (rx_rise)
    );

    abd_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_clr),
        .inc_i    (cnt_inc),
        .cnt_o    (cnt_val),
        .at_max_o (cnt_max)
    );

    abd_ctrl #(.CNT_W(CNT_W), .EDGES(EDGES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rx_rise),
        .tick_i     (baud_tick),
        .en_wr_i    (en_wr),
        .en_wdata_i (en_wdata),
        .ovf_clr_i  (ovf_clr),
        .data_rd_i  (data_rd),
        .cnt_i      (cnt_val),
        .cnt_max_i  (cnt_max),
        .cnt_clr_o  (cnt_clr),
        .cnt_inc_o  (cnt_inc),
        .div_o      (divisor),
        .ovf_o      (ovf_flag),
        .irq_o      (rx_irq),
        .en_o       (en_status)
    );

endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ovf_clr,
    input logic             data_rd,
    input logic [CNT_W-1:0] divisor,
    input logic             ovf_flag,
    input logic             rx_irq,
    input logic             en_status
);

    AST_IRQ_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> !en_status); // R4

    AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !en_status) |=> !rx_irq); // R5

    AST_DIV_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_status |=> $stable(divisor)); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R8

    AST_OVF_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !en_status) |=> !ovf_flag); // R9

    AST_OVF_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && en_status && ovf_flag) |=> ovf_flag); // R10

endmodule

bind abd_top abd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_clr   (ovf_clr),
    .data_rd   (data_rd),
    .divisor   (divisor),
    .ovf_flag  (ovf_flag),
    .rx_irq    (rx_irq),
    .en_status (en_status)
);

// File: tb/abd_top_bench.sv
`timescale 1ns/1ps
module abd_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_pin = 1'b1;
    logic        baud_tick = 1'b0;
    logic        en_wr = 1'b0;
    logic        en_wdata = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        data_rd = 1'b0;
    logic [15:0] divisor;
    logic        ovf_flag;
    logic        rx_irq;
    logic        en_status;

    always #2.5 clk = ~clk;

    abd_top u_abd_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_pin    (rx_pin),
        .baud_tick (baud_tick),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .ovf_clr   (ovf_clr),
        .data_rd   (data_rd),
        .divisor   (divisor),
        .ovf_flag  (ovf_flag),
        .rx_irq    (rx_irq),
        .en_status (en_status)
    );

    typedef struct {
        logic [15:0] div;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   step_n = 0;
    bit   done = 1'b0;
    logic irq_prev = 1'b0;
    logic [15:0] last_div = 16'h0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic step(input logic pin, input logic tick, input logic wr = 1'b0,
                        input logic wd = 1'b0, input logic clr = 1'b0, input logic rd = 1'b0);
        @(negedge clk);
        rx_pin    = pin;
        baud_tick = tick;
        en_wr     = wr;
        en_wdata  = wd;
        ovf_clr   = clr;
        data_rd   = rd;
        step_n++;
    endtask

    // Sync character of five rising edges, P cycles apart; tick on sample index multiple of tdiv.
    task automatic sync_char(input int p, input int tdiv, input int clr_at, input string tag);
        int   base;
        int   c1;
        int   c5;
        int   total;
        exp_t e;
        base  = step_n;
        c1    = base + 1 + p / 2;
        c5    = base + 1 + 4 * p + p / 2;
        total = 0;
        for (int s = c1 + 3; s <= c5 + 1; s++) begin
            if ((s % tdiv) == 0) total++;
        end
        e.div = total[15:0];
        e.ovf = (total >= 65536);
        e.tag = tag;
        exp_q.push_back(e);
        last_div = e.div;
        for (int i = 0; i < 5 * p + 6; i++) begin
            logic pin;
            int   s;
            s   = step_n + 1;
            pin = (i >= 5 * p) ? 1'b1 : ((i % p) >= p / 2);
            step(pin, ((s % tdiv) == 0), 1'b0, 1'b0, (i == clr_at));
            if (i == clr_at + 1) begin
                chk("R10 ovf_flag after clear while enabled", ovf_flag, 1);
                chk("R10 en_status during measurement", en_status, 1);
            end
        end
        chk("R4 scoreboard drained", exp_q.size(), 0);
    endtask

    always @(negedge clk) begin
        if (rst_n && rx_irq && !irq_prev) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11 unexpected rx_irq actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " divisor"}, divisor, e.div);
                chk({e.tag, " ovf_flag"}, ovf_flag, e.ovf);
                chk("R4 en_status dropped", en_status, 0);
            end
        end
        irq_prev <= rx_irq;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step(1'b1, 1'b0);
        rst_n = 1'b1;
        step(1'b1, 1'b0);
        chk("R1 divisor", divisor, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 rx_irq", rx_irq, 0);
        chk("R1 en_status", en_status, 0);

        // R2: arm
        step(1'b1, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk("R2 en_status after write", en_status, 1);

        // R3 R4: period 4, tick every cycle -> 15
        sync_char(4, 1, -5, "R3 R4 p4");
        chk("R3 value", divisor, 15);

        // R5: read clears interrupt
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0);
        chk("R5 rx_irq after read", rx_irq, 0);

        // R6: edges while disabled
        for (int k = 0; k < 6; k++) begin
            repeat (3) step(1'b0, 1'b1);
            repeat (3) step(1'b1, 1'b1);
        end
        chk("R6 rx_irq", rx_irq, 0);
        chk("R6 divisor", divisor, 15);
        chk("R6 en_status", en_status, 0);

        // R3: period 8, tick every third sample
        step(1'b1, 1'b0, 1'b1, 1'b1);
        sync_char(8, 3, -5, "R3 p8 div3");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

        // R11: abort after two rising edges
        step(1'b1, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 2; k++) begin
            repeat (3) step(1'b0, 1'b1);
            repeat (3) step(1'b1, 1'b1);
        end
        step(1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b1);
        chk("R2 R11 en_status after disable", en_status, 0);
        for (int k = 0; k < 4; k++) begin
            repeat (3) step(1'b0, 1'b1);
            repeat (3) step(1'b1, 1'b1);
        end
        repeat (3) step(1'b1, 1'b0);
        chk("R11 rx_irq after abort", rx_irq, 0);
        chk("R11 divisor kept", divisor, {16'h0, last_div});
        chk("R11 ovf_flag", ovf_flag, 0);

        // R7 R10: overflow run, clear attempt shortly before the fifth edge
        step(1'b1, 1'b0, 1'b1, 1'b1);
        sync_char(16400, 1, 4 * 16400 + 16400 / 2 - 20, "R7 overflow");
        repeat (4) step(1'b1, 1'b0);
        chk("R8 ovf_flag held", ovf_flag, 1);
        chk("R7 divisor wrapped", divisor, 63);

        // R9: clear with enable low
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0);
        chk("R9 ovf_flag cleared", ovf_flag, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule